// File: doc/BRIEF.md
# Multi-Channel Pulse-Width Modulator with Prescaled Counters

This block drives a bank of independent pulse-width modulated outputs from a simple 32-bit register bus. Each channel owns a period counter that advances once per prescaled clock tick. The prescaler is selected per channel from a fixed, non-uniform set of divide ratios. Inside each period, a window of counts marks the active state. The output level for the active state and for the inactive state is programmed separately.

Software programs two registers per channel: a window register and a period register. It then enables channels through one shared enable register. Every register can be written in four ways: plain replace, bit-set, bit-clear and bit-toggle. Each way has its own word inside the register's 16-byte slot. The channel settings that software writes are only copied into the counting logic when a period ends, or at the moment a channel is enabled. A period that has already started therefore always finishes with the settings it began with.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads zero and every output is low.
- R2: The enable register sits at byte offset 0x00, and bit n enables channel n. A plain write to the base word replaces the whole value, and bits at or above the channel count read as zero.
- R3: Each register's slot has four words. Base+0x0 replaces, base+0x4 sets the written one bits, base+0x8 clears the written one bits, and base+0xC inverts the written one bits. A read from any of the four words returns the current value.
- R4: The window register of channel n is at 0x10 + 0x20*n and its period register is at 0x20 + 0x20*n. Period register bits 31:23 read as zero. Offsets that are not word aligned, the slots of channels at or above the channel count, and any other offset all read zero and ignore writes.
- R5: A running channel counts prescaled ticks from 0 up to the period value in period bits 15:0 and then wraps to 0, so one period lasts (period+1) ticks.
- R6: Period bits 22:20 pick the tick divide ratio. Codes 0 to 7 select 1, 2, 4, 8, 16, 64, 256 and 1024 clocks per tick.
- R7: The channel is in its active state while the count is at least window bits 15:0 and below window bits 31:16. With a start of 0 and an end of d, the channel is active for d of the (period+1) ticks.
- R8: Period bits 17:16 give the output level in the active state, and bits 19:18 give the level in the inactive state. Code 3 drives the output high. Codes 0, 1 and 2 drive it low.
- R9: While its enable bit is clear, a channel drives low and keeps its tick divider and counter at zero. In the clock after its enable bit is set, it loads its settings and presents count 0.
- R10: Settings written while a channel runs take effect only at the next wrap. A write that commits on the same clock edge as a wrap first applies at the wrap after that one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pwm_out | output | NCH | One output per channel |

## Verification
A bus write to a channel's window register can commit on the same clock edge at which that channel's counter wraps and reloads its working settings. The bench times this collision exactly. It waits for the rising output edge that marks count 0, lets nine more clocks pass, and then commits the write on the tenth edge of a 10-tick period. It judges the outcome by counting high samples in the two following periods. The first period must still show the old duty and the second must show the new one. A second case writes one clock after count 0 and must show the new duty exactly one period later.

// File: rtl/pwm_pkg.sv
// Package of shared types and pure functions for the PWM bank.
// Assumes: 16-bit counts, prescale codes of 3 bits, level codes of 2 bits.
package pwm_pkg;

    // Write flavour, taken from address bits 3:2 of each register slot.
    typedef enum logic [1:0] {
        OP_PUT = 2'd0,
        OP_SET = 2'd1,
        OP_CLR = 2'd2,
        OP_INV = 2'd3
    } wr_op_e;

    localparam int unsigned DIV_W = 10;

    // Working copy of one channel's settings, held for a whole period.
    typedef struct packed {
        logic [15:0] per;
        logic [2:0]  div;
        logic [1:0]  lv_on;
        logic [1:0]  lv_off;
        logic [15:0] t_on;
        logic [15:0] t_off;
    } work_t;

    // Merge a bus write into a register value according to the flavour.
    function automatic logic [31:0] apply_op(wr_op_e op, logic [31:0] cur, logic [31:0] wd);
        case (op)
            OP_SET:  return cur | wd;
            OP_CLR:  return cur & ~wd;
            OP_INV:  return cur ^ wd;
            default: return wd;
        endcase
    endfunction

    // Last divider count for a prescale code (ratio minus one).
    function automatic logic [DIV_W-1:0] div_last(logic [2:0] code);
        case (code)
            3'd0:    return 10'd0;
            3'd1:    return 10'd1;
            3'd2:    return 10'd3;
            3'd3:    return 10'd7;
            3'd4:    return 10'd15;
            3'd5:    return 10'd63;
            3'd6:    return 10'd255;
            default: return 10'd1023;
        endcase
    endfunction

    // Only code 3 drives high; every other code drives low.
    function automatic logic level_of(logic [1:0] code);
        return code == 2'b11;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
// Register file and bus decode for the PWM bank.
// Each register owns a 16-byte slot: put, set, clear and invert words.
// Slot 0 holds the enable register. Slot 2n+1 holds channel n's window
// register and slot 2n+2 holds its period register.
// Assumes: ADDR_W leaves room for 2*NCH+1 slots; reads are combinational.
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bus_en,
    input  logic                    bus_we,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    output logic [NCH-1:0]          ctrl_o,
    output logic [NCH-1:0][31:0]    act_o,
    output logic [NCH-1:0][22:0]    per_o
);
    localparam int unsigned SLOT_W = ADDR_W - 4;

    logic [SLOT_W-1:0] slot;
    wr_op_e            op;
    logic              aligned;
    logic              wr;
    logic              ctrl_hit;
    logic [NCH-1:0]    act_hit;
    logic [NCH-1:0]    per_hit;
    logic [NCH-1:0]    ctrl_q;
    logic [31:0]       act_q [NCH];
    logic [22:0]       per_q [NCH];

    // Split the byte address into slot, write flavour and alignment.
    assign slot     = bus_addr[ADDR_W-1:4];
    assign op       = wr_op_e'(bus_addr[3:2]);
    assign aligned  = bus_addr[1:0] == 2'b00;
    assign wr       = bus_en && bus_we;
    assign ctrl_hit = aligned && (slot == '0);

    // Enable register update.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '0;
        else if (wr && ctrl_hit)
            ctrl_q <= NCH'(apply_op(op, {{(32-NCH){1'b0}}, ctrl_q}, bus_wdata));
    end

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        assign act_hit[n] = aligned && (slot == SLOT_W'(2*n + 1));
        assign per_hit[n] = aligned && (slot == SLOT_W'(2*n + 2));

        // Window register update for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                act_q[n] <= '0;
            else if (wr && act_hit[n])
                act_q[n] <= apply_op(op, act_q[n], bus_wdata);
        end

        // Period register update for this channel.
        always_ff @(posedge clk) begin
            if (!rst_n)
                per_q[n] <= '0;
            else if (wr && per_hit[n])
                per_q[n] <= 23'(apply_op(op, {9'b0, per_q[n]}, bus_wdata));
        end

        assign act_o[n] = act_q[n];
        assign per_o[n] = per_q[n];
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_hit)
            bus_rdata = {{(32-NCH){1'b0}}, ctrl_q};
        for (int n = 0; n < NCH; n++) begin
            if (act_hit[n]) bus_rdata = act_q[n];
            if (per_hit[n]) bus_rdata = {9'b0, per_q[n]};
        end
    end

    assign ctrl_o = ctrl_q;

    AST_SET_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl_hit && op == OP_SET) |=>
        ((ctrl_q & $past(bus_wdata[NCH-1:0])) == $past(bus_wdata[NCH-1:0]))); // R3
    AST_CLR_DROPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && ctrl_hit && op == OP_CLR) |=>
        ((ctrl_q & $past(bus_wdata[NCH-1:0])) == '0)); // R3
    AST_IDLE_HOLDS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && ctrl_hit) |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/pwm_prescale.sv
// Tick divider for one channel: emits one tick every N clocks, where N
// comes from the 3-bit prescale code.
// Assumes: code_i changes only while run_i is low or on a tick edge.
module pwm_prescale
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic [2:0] code_i,
    output logic       tick_o
);
    logic [DIV_W-1:0] pdiv_q;
    logic [DIV_W-1:0] last;

    assign last   = div_last(code_i);
    assign tick_o = run_i && (pdiv_q == last);

    // Divider count: cleared when stopped, wraps after the last count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i)
            pdiv_q <= '0;
        else if (pdiv_q == last)
            pdiv_q <= '0;
        else
            pdiv_q <= pdiv_q + 1'b1;
    end

    AST_DIV_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pdiv_q == '0)); // R9
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pdiv_q <= last); // R6

endmodule

// File: rtl/pwm_chan.sv
// One PWM channel: working settings, period counter and output level.
// Settings are copied from the registers on enable and at each wrap.
// Assumes: en_i comes from a register, and the registers hold steady between bus writes.
module pwm_chan
    import pwm_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en_i,
    input  logic [31:0] act_i,
    input  logic [22:0] per_i,
    output logic        out_o
);
    work_t       w_q;
    work_t       w_new;
    logic        run_q;
    logic [15:0] cnt_q;
    logic        go;
    logic        tick;
    logic        wrap;
    logic        in_on;

    // Gather the register fields into the working layout.
    assign w_new = '{per:    per_i[15:0],
                     div:    per_i[22:20],
                     lv_on:  per_i[17:16],
                     lv_off: per_i[19:18],
                     t_on:   act_i[15:0],
                     t_off:  act_i[31:16]};

    assign go   = run_q && en_i;
    assign wrap = tick && (cnt_q == w_q.per);

    pwm_prescale u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (go),
        .code_i (w_q.div),
        .tick_o (tick)
    );

    // Run state, counter and working copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            cnt_q <= '0;
            w_q   <= '0;
        end else if (!en_i) begin
            run_q <= 1'b0;
            cnt_q <= '0;
        end else if (!run_q) begin
            run_q <= 1'b1;
            cnt_q <= '0;
            w_q   <= w_new;
        end else if (wrap) begin
            cnt_q <= '0;
            w_q   <= w_new;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Output level from the window comparison.
    assign in_on = (cnt_q >= w_q.t_on) && (cnt_q < w_q.t_off);
    assign out_o = go && (in_on ? level_of(w_q.lv_on) : level_of(w_q.lv_off));

    AST_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (cnt_q == '0 && !run_q)); // R9
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (cnt_q <= w_q.per)); // R5
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (go && wrap) |=> (cnt_q == '0)); // R5
    AST_WORK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !wrap) |=> $stable(w_q)); // R10

endmodule

// File: rtl/pwm_bank.sv
// Top of the PWM bank: register file plus NCH channels.
// Assumes: 1 <= NCH <= 8 and a single clock domain.
module pwm_bank
    import pwm_pkg::*;
#(
    parameter int unsigned NCH    = 4,
    parameter int unsigned ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [NCH-1:0]    pwm_out
);
    logic [NCH-1:0]         ctrl_w;
    logic [NCH-1:0][31:0]   act_w;
    logic [NCH-1:0][22:0]   per_w;

    pwm_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .ctrl_o    (ctrl_w),
        .act_o     (act_w),
        .per_o     (per_w)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        pwm_chan u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .en_i  (ctrl_w[n]),
            .act_i (act_w[n]),
            .per_i (per_w[n]),
            .out_o (pwm_out[n])
        );
    end

    AST_OFF_IS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl_w[0]) |-> !pwm_out[0]); // R9

endmodule

// File: tb/sim_pwm_bank.sv
// Directed bench for pwm_bank: one task per scenario.
module sim_pwm_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  pwm_out;
    int          n_vec = 0;
    int          n_bad = 0;

    always #10 clk = ~clk;

    pwm_bank #(.NCH(4), .ADDR_W(12)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_now(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_now(a, d);
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic count_hi(input int ch, input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (!prev && pwm_out[ch]) return;
            prev = pwm_out[ch];
        end
    endtask

    task automatic t_reset;
        logic [31:0] d;
        bus_rd(12'h000, d); chk("R1 ctrl", d, 0);
        bus_rd(12'h010, d); chk("R1 act0", d, 0);
        bus_rd(12'h080, d); chk("R1 per3", d, 0);
        chk("R1 outputs", {28'b0, pwm_out}, 0);
    endtask

    task automatic t_regs;
        logic [31:0] d;
        bus_wr(12'h010, 32'h1234_5678);
        bus_rd(12'h010, d); chk("R4 act0 readback", d, 32'h1234_5678);
        bus_wr(12'h080, 32'hFFFF_FFFF);
        bus_rd(12'h080, d); chk("R4 per3 upper bits", d, 32'h007F_FFFF);
    endtask

    task automatic t_alias;
        logic [31:0] d;
        bus_wr(12'h000, 32'hFFFF_FFF5);
        bus_rd(12'h000, d); chk("R2 plain write", d, 32'h5);
        bus_wr(12'h004, 32'h2);
        bus_rd(12'h000, d); chk("R3 set", d, 32'h7);
        bus_wr(12'h008, 32'h4);
        bus_rd(12'h000, d); chk("R3 clear", d, 32'h3);
        bus_wr(12'h00C, 32'h9);
        bus_rd(12'h00C, d); chk("R3 invert, read at alias", d, 32'hA);
        bus_wr(12'h014, 32'h8000_0000);
        bus_rd(12'h018, d); chk("R3 set on window reg", d, 32'h9234_5678);
        bus_wr(12'h000, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        bus_wr(12'h090, 32'hFFFF);
        bus_rd(12'h090, d); chk("R4 slot beyond NCH", d, 0);
        bus_wr(12'h011, 32'h0);
        bus_rd(12'h011, d); chk("R4 misaligned read", d, 0);
        bus_rd(12'h010, d); chk("R4 misaligned write ignored", d, 32'h9234_5678);
        bus_rd(12'h400, d); chk("R4 far offset", d, 0);
    endtask

    task automatic t_duty;
        int hi;
        bus_wr(12'h020, 32'h000B_0009);
        bus_wr(12'h010, 32'h0003_0000);
        count_hi(0, 5, hi); chk("R9 disabled low", hi, 0);
        bus_wr(12'h004, 32'h1);
        count_hi(0, 5, hi);
        count_hi(0, 10, hi); chk("R7 duty 3 of 10", hi, 3);
        count_hi(0, 30, hi); chk("R5 three periods", hi, 9);
    endtask

    task automatic t_shadow;
        int hi;
        int hi2;
        wait_rise(0);
        wr_now(12'h010, 32'h0007_0000);
        count_hi(0, 9, hi); chk("R10 old duty kept", hi + 1, 3);
        count_hi(0, 10, hi); chk("R10 new duty at wrap", hi, 7);
        wait_rise(0);
        repeat (9) @(negedge clk);
        wr_now(12'h010, 32'h0003_0000);
        count_hi(0, 10, hi);  chk("R10 write on wrap edge: old", hi, 7);
        count_hi(0, 10, hi2); chk("R10 write on wrap edge: new", hi2, 3);
    endtask

    task automatic t_window;
        int hi;
        bus_wr(12'h040, 32'h000B_0009);
        bus_wr(12'h030, 32'h0005_0002);
        bus_wr(12'h004, 32'h2);
        count_hi(1, 5, hi);
        count_hi(1, 20, hi); chk("R7 window 2..5", hi, 6);
    endtask

    task automatic t_levels;
        int hi;
        bus_wr(12'h040, 32'h000E_0009);
        count_hi(1, 25, hi);
        count_hi(1, 10, hi); chk("R8 inverted levels", hi, 7);
        bus_wr(12'h040, 32'h0005_0009);
        count_hi(1, 25, hi);
        count_hi(1, 10, hi); chk("R8 codes 1 drive low", hi, 0);
    endtask

    task automatic t_prescale;
        int hi;
        bus_wr(12'h060, 32'h002B_0003);
        bus_wr(12'h050, 32'h0002_0000);
        bus_wr(12'h004, 32'h4);
        count_hi(2, 8, hi);
        count_hi(2, 16, hi); chk("R6 code 2 ratio 4", hi, 8);
        bus_wr(12'h080, 32'h005B_0001);
        bus_wr(12'h070, 32'h0001_0000);
        bus_wr(12'h004, 32'h8);
        count_hi(3, 10, hi);
        count_hi(3, 128, hi); chk("R6 code 5 ratio 64", hi, 64);
        bus_wr(12'h008, 32'h8);
        bus_wr(12'h080, 32'h007B_0001);
        bus_wr(12'h004, 32'h8);
        count_hi(3, 10, hi);
        count_hi(3, 2048, hi); chk("R6 code 7 ratio 1024", hi, 1024);
    endtask

    task automatic t_disable;
        int hi;
        bus_wr(12'h008, 32'h1);
        count_hi(0, 20, hi); chk("R9 cleared channel low", hi, 0);
        bus_wr(12'h004, 32'h1);
        @(negedge clk); chk("R9 not yet running", {31'b0, pwm_out[0]}, 0);
        @(negedge clk); chk("R9 count 0 next clock", {31'b0, pwm_out[0]}, 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_regs();
        t_alias();
        t_unmapped();
        t_duty();
        t_shadow();
        t_window();
        t_levels();
        t_prescale();
        t_disable();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule